// File: doc/BRIEF.md
# Clock-Mode Controller with Lock Timer

This block owns the programmable mode word of a clock generator. Software writes a 16-bit control word. The block turns that word into three things: a run request for an external PLL, a choice between divider mode and PLL mode for the core clock, and a clock multiplier expressed as an exact fixed-point ratio. The analog PLL, the frequency synthesis and the glitch-free clock mux sit outside the block. They consume these outputs.

A PLL output is not safe to use until the loop has settled. When software asks for PLL mode, the block therefore keeps the core in divider mode and starts a lock timer. The timer is a down-counter that advances once every 16 input clocks. Only when the timer runs out does the active mode change to PLL, and a read-only status bit reports the change. Writing divider mode takes effect at once and abandons any lock wait in progress.

Top module: `clkmode_ctrl`

## Requirements
- R1: After reset, rd_data reads 0, pll_run is 0, pll_active is 0, ratio_err is 0 and mult_ratio is 2, which is a ratio of 0.5.
- R2: A write stores bits 15:1 of wr_data. Bit 0 of the write is ignored, and rd_data bit 0 always returns pll_active. The word layout is: bits 15:12 multiplier field, bit 11 fractional select, bits 10:3 lock count, bit 2 PLL on, bit 1 PLL mode select.
- R3: pll_run is 1 when the stored PLL-on bit or the stored mode-select bit is 1, and 0 only when both are 0.
- R4: In divider mode, mult_ratio is in units of 0.25. It is 2 for multiplier field values 0 to 14 and 1 for field value 15.
- R5: In PLL mode with the fractional select at 0, mult_ratio is 4 × (field + 1) for field values 0 to 14.
- R6: In PLL mode with the fractional select at 1, mult_ratio is 2 × (field + 1) for an even field value and equals the field value for an odd one.
- R7: A write that starts a lock wait keeps pll_active at 0 and the divider ratio in force. If N is the lock count, pll_active becomes 1, with the PLL ratio, exactly 16 × N input cycles after the write edge.
- R8: A mode-select-1 write while mode select is already 1 reloads the lock timer only when the multiplier field or the fractional select changes. When only the lock count or the on bit changes, pll_active is unaffected.
- R9: A write with mode select 0 sets pll_active to 0 on the write edge and cancels any pending lock wait.
- R10: A mode-select-1 write with fractional select 0 and field 15 is reserved. It sets ratio_err and leaves pll_active and mult_ratio unchanged. The next non-reserved write clears ratio_err.
- R11: A lock count of 0 behaves like a count of 1, so PLL mode is entered 16 input cycles after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Writes wr_data into the control word |
| wr_data | input | 16 | Control word to write |
| rd_data | output | 16 | Stored control word, with status in bit 0 |
| pll_run | output | 1 | Run request to the external PLL |
| pll_active | output | 1 | Core clock in PLL mode (status) |
| mult_ratio | output | MULT_W (7) | Active multiplier in units of 0.25 |
| ratio_err | output | 1 | Last write carried the reserved multiplier code |

## Verification
Every output is a register or decodes directly from one. rd_data, pll_run, ratio_err and the divider-side effects of a write are therefore due one edge after the write. The bench samples them half a cycle after that edge.

The PLL switch is due 16 × max(N,1) edges after the write edge. The bench counts falling edges from the write and checks pll_active and mult_ratio one cycle before that edge as well as at it. This pins the lock time to the exact cycle.

No-effect cases, such as a reserved code or a write that only changes the lock count, are observed on pll_active and mult_ratio both right after the write and after a wait longer than any lock time that could have started.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;

   localparam int CTRL_W = 16;
   localparam int MUL_W  = 4;
   localparam int LOCK_W = 8;

   // Control word, MSB first; bit positions are decoded by software.
   typedef struct packed {
      logic [MUL_W-1:0]  mul;
      logic              frac;
      logic [LOCK_W-1:0] lock;
      logic              run_on;
      logic              pll_sel;
      logic              stat;
   } ctrl_word_t;

endpackage

// File: rtl/clkmode_ratio.sv
module clkmode_ratio #(
   parameter int FIELD_W = 4,
   parameter int MULT_W  = 7
) (
   input  logic               pll_mode_i,
   input  logic               frac_i,
   input  logic [FIELD_W-1:0] field_i,
   output logic [MULT_W-1:0]  ratio_o
);

   if (MULT_W < FIELD_W + 3) begin : g_bad_width
      $error("clkmode_ratio: MULT_W too narrow for the largest ratio");
   end

   logic [MULT_W-1:0] fx;
   assign fx = MULT_W'(field_i);

   always_comb begin
      if (!pll_mode_i) begin
         ratio_o = (&field_i) ? MULT_W'(1) : MULT_W'(2);
      end else if (!frac_i) begin
         ratio_o = (fx + MULT_W'(1)) << 2;
      end else if (field_i[0]) begin
         ratio_o = fx;
      end else begin
         ratio_o = (fx + MULT_W'(1)) << 1;
      end
   end

endmodule

// File: rtl/clkmode_lock_timer.sv
module clkmode_lock_timer #(
   parameter int CNT_W      = 8,
   parameter int PRESC_LOG2 = 4
) (
   input  logic             clk_in,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             cancel_i,
   input  logic [CNT_W-1:0] init_i,
   output logic             expire_o
);

   if (CNT_W < 1 || PRESC_LOG2 < 0 || PRESC_LOG2 > 16) begin : g_bad_cfg
      $error("clkmode_lock_timer: unsupported CNT_W or PRESC_LOG2");
   end

   logic             pend_q;
   logic [CNT_W-1:0] cnt_q;
   logic             tick;
   logic             last;

   if (PRESC_LOG2 == 0) begin : g_no_presc
      assign tick = pend_q;
   end else begin : g_presc
      logic [PRESC_LOG2-1:0] presc_q;
      always_ff @(posedge clk_in) begin
         if (!rst_n || start_i || cancel_i || !pend_q) begin
            presc_q <= '0;
         end else begin
            presc_q <= presc_q + 1'b1;
         end
      end
      assign tick = pend_q && (&presc_q);
   end

   assign last     = (cnt_q == '0) || (cnt_q == CNT_W'(1));
   assign expire_o = tick && last && !start_i && !cancel_i;

   always_ff @(posedge clk_in) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         cnt_q  <= '0;
      end else if (cancel_i) begin
         pend_q <= 1'b0;
      end else if (start_i) begin
         pend_q <= 1'b1;
         cnt_q  <= init_i;
      end else if (tick) begin
         if (last) begin
            pend_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   // Count never climbs except through a reload.
   assert_cnt_monotone_R7: assert property (@(posedge clk_in) disable iff (!rst_n)
      (pend_q && !start_i && !cancel_i) |=> (cnt_q <= $past(cnt_q)));

   assert_cancel_idles_R9: assert property (@(posedge clk_in) disable iff (!rst_n)
      cancel_i |=> !pend_q);

endmodule

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl
   import clkmode_pkg::*;
#(
   parameter int PRESC_LOG2 = 4,
   parameter int MULT_W     = 7
) (
   input  logic              clk_in,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [15:0]       wr_data,
   output logic [15:0]       rd_data,
   output logic              pll_run,
   output logic              pll_active,
   output logic [MULT_W-1:0] mult_ratio,
   output logic              ratio_err
);

   if ($bits(ctrl_word_t) != CTRL_W || CTRL_W != 16) begin : g_bad_layout
      $error("clkmode_ctrl: control word layout does not match CTRL_W");
   end

   ctrl_word_t       w_new;
   ctrl_word_t       ctl_q;
   ctrl_word_t       rd_w;
   logic [MUL_W-1:0] act_mul_q;
   logic             act_frac_q;
   logic             status_q;
   logic             err_q;
   logic             reserved_w;
   logic             changed_w;
   logic             reload_w;
   logic             cancel_w;
   logic             expire;

   assign w_new      = wr_data;
   assign reserved_w = w_new.pll_sel && !w_new.frac && (&w_new.mul);
   assign changed_w  = (w_new.mul != act_mul_q) || (w_new.frac != act_frac_q);
   assign reload_w   = wr_en && w_new.pll_sel && !reserved_w && (!ctl_q.pll_sel || changed_w);
   assign cancel_w   = wr_en && !w_new.pll_sel;

   always_ff @(posedge clk_in) begin
      if (!rst_n) begin
         ctl_q      <= '0;
         act_mul_q  <= '0;
         act_frac_q <= 1'b0;
         status_q   <= 1'b0;
         err_q      <= 1'b0;
      end else begin
         if (wr_en) begin
            ctl_q      <= w_new;
            ctl_q.stat <= 1'b0;
            err_q      <= reserved_w;
            if (!reserved_w) begin
               act_mul_q  <= w_new.mul;
               act_frac_q <= w_new.frac;
            end
         end
         if (cancel_w || reload_w) begin
            status_q <= 1'b0;
         end else if (expire) begin
            status_q <= 1'b1;
         end
      end
   end

   clkmode_lock_timer #(
      .CNT_W      (LOCK_W),
      .PRESC_LOG2 (PRESC_LOG2)
   ) u_timer (
      .clk_in   (clk_in),
      .rst_n    (rst_n),
      .start_i  (reload_w),
      .cancel_i (cancel_w),
      .init_i   (w_new.lock),
      .expire_o (expire)
   );

   clkmode_ratio #(
      .FIELD_W (MUL_W),
      .MULT_W  (MULT_W)
   ) u_ratio (
      .pll_mode_i (status_q),
      .frac_i     (act_frac_q),
      .field_i    (act_mul_q),
      .ratio_o    (mult_ratio)
   );

   always_comb begin
      rd_w      = ctl_q;
      rd_w.stat = status_q;
   end

   assign rd_data    = rd_w;
   assign pll_run    = ctl_q.run_on | ctl_q.pll_sel;
   assign pll_active = status_q;
   assign ratio_err  = err_q;

   assert_run_when_pll_R3: assert property (@(posedge clk_in) disable iff (!rst_n)
      pll_active |-> pll_run);

   assert_rise_on_expire_R7: assert property (@(posedge clk_in) disable iff (!rst_n)
      $rose(status_q) |-> $past(expire));

   assert_reload_drops_R8: assert property (@(posedge clk_in) disable iff (!rst_n)
      reload_w |=> !pll_active);

   assert_div_write_R9: assert property (@(posedge clk_in) disable iff (!rst_n)
      (wr_en && !wr_data[1]) |=> !pll_active);

   assert_reserved_hold_R10: assert property (@(posedge clk_in) disable iff (!rst_n)
      (wr_en && reserved_w && !expire) |=> ($stable(pll_active) && $stable(mult_ratio) && ratio_err));

   assert_no_reserved_active_R10: assert property (@(posedge clk_in) disable iff (!rst_n)
      pll_active |-> !(!act_frac_q && (&act_mul_q)));

endmodule

// File: tb/clkmode_ctrl_test.sv
module clkmode_ctrl_test;

   logic        clk_in = 1'b0;
   logic        rst_n  = 1'b0;
   logic        wr_en  = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic        pll_run;
   logic        pll_active;
   logic [6:0]  mult_ratio;
   logic        ratio_err;

   int checks = 0;
   int errors = 0;

   always #10 clk_in = ~clk_in;

   clkmode_ctrl #(.PRESC_LOG2(4), .MULT_W(7)) uut (
      .clk_in     (clk_in),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .rd_data    (rd_data),
      .pll_run    (pll_run),
      .pll_active (pll_active),
      .mult_ratio (mult_ratio),
      .ratio_err  (ratio_err)
   );

   function automatic logic [15:0] mk(int f, int fr, int cnt, int on, int sel);
      return {f[3:0], fr[0], cnt[7:0], on[0], sel[0], 1'b0};
   endfunction

   function automatic int exp_div(int f);
      return (f == 15) ? 1 : 2;
   endfunction

   function automatic int exp_int(int f);
      return 4 * (f + 1);
   endfunction

   function automatic int exp_frac(int f);
      return (f % 2 == 1) ? f : 2 * (f + 1);
   endfunction

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   // Leaves the bench half a cycle after the write edge.
   task automatic wr(logic [15:0] d);
      @(negedge clk_in);
      wr_en   = 1'b1;
      wr_data = d;
      @(negedge clk_in);
      wr_en = 1'b0;
   endtask

   task automatic wait_cyc(int n);
      for (int i = 0; i < n; i++) @(negedge clk_in);
   endtask

   // Lock wait from current point (just after the write edge).
   task automatic lock_wait(string tag, int n, int pre_ratio, int post_ratio);
      int due;
      due = 16 * ((n < 1) ? 1 : n);
      chk({tag, " status at write"}, pll_active, 0);
      chk({tag, " ratio at write"}, mult_ratio, pre_ratio);
      wait_cyc(due - 1);
      chk({tag, " status one before due"}, pll_active, 0);
      chk({tag, " ratio one before due"}, mult_ratio, pre_ratio);
      wait_cyc(1);
      chk({tag, " status at due"}, pll_active, 1);
      chk({tag, " ratio at due"}, mult_ratio, post_ratio);
      chk({tag, " rd status bit"}, rd_data[0], 1);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(1);
      chk("R1 rd_data", rd_data, 0);
      chk("R1 pll_run", pll_run, 0);
      chk("R1 pll_active", pll_active, 0);
      chk("R1 ratio_err", ratio_err, 0);
      chk("R1 mult_ratio", mult_ratio, 2);
   endtask

   task automatic t_readback_run();
      wr(mk(5, 0, 8'h3C, 1, 0) | 16'h0001);
      chk("R2 readback bit0 ignored", rd_data, mk(5, 0, 8'h3C, 1, 0));
      chk("R3 on bit alone", pll_run, 1);
      chk("R4 divider field 5", mult_ratio, 2);
      wr(mk(0, 1, 8'hA5, 0, 0));
      chk("R2 readback", rd_data, mk(0, 1, 8'hA5, 0, 0));
      chk("R3 both off", pll_run, 0);
      chk("R9 divider keeps status 0", pll_active, 0);
   endtask

   task automatic t_div_decode();
      for (int f = 0; f < 16; f++) begin
         wr(mk(f, f % 2, 0, 0, 0));
         chk($sformatf("R4 divider field %0d", f), mult_ratio, exp_div(f));
         chk("R4 divider status", pll_active, 0);
      end
   endtask

   task automatic t_pll_int();
      for (int f = 0; f < 15; f++) begin
         wr(mk(f, 0, 0, 0, 1));
         chk("R3 select alone runs", pll_run, 1);
         lock_wait($sformatf("R5 R11 int field %0d", f), 0, exp_div(f), exp_int(f));
      end
   endtask

   task automatic t_pll_frac();
      for (int f = 0; f < 16; f++) begin
         wr(mk(f, 1, 0, 0, 1));
         lock_wait($sformatf("R6 frac field %0d", f), 0, exp_div(f), exp_frac(f));
      end
   endtask

   task automatic t_lock_count();
      wr(mk(3, 0, 0, 0, 0));
      wr(mk(3, 0, 5, 0, 1));
      chk("R7 rd status during wait", rd_data[0], 0);
      lock_wait("R7 count 5", 5, 2, 16);
   endtask

   task automatic t_no_reload();
      wr(mk(3, 0, 9, 1, 1));
      chk("R8 same ratio keeps status", pll_active, 1);
      chk("R8 same ratio keeps ratio", mult_ratio, 16);
      wait_cyc(200);
      chk("R8 status after long wait", pll_active, 1);
      wr(mk(4, 0, 2, 1, 1));
      lock_wait("R8 field change reloads", 2, 2, 20);
   endtask

   task automatic t_reserved();
      wr(mk(15, 0, 3, 0, 1));
      chk("R10 err set", ratio_err, 1);
      chk("R10 status held", pll_active, 1);
      chk("R10 ratio held", mult_ratio, 20);
      wait_cyc(80);
      chk("R10 status after wait", pll_active, 1);
      chk("R10 ratio after wait", mult_ratio, 20);
      wr(mk(4, 0, 2, 0, 1));
      chk("R10 err cleared", ratio_err, 0);
      chk("R10 status after clear", pll_active, 1);
   endtask

   task automatic t_div_back();
      wr(mk(4, 0, 2, 0, 0));
      chk("R9 immediate divider", pll_active, 0);
      chk("R9 divider ratio", mult_ratio, 2);
      chk("R3 run off", pll_run, 0);
      wr(mk(6, 0, 3, 0, 1));
      wait_cyc(20);
      wr(mk(6, 0, 3, 0, 0));
      chk("R9 cancel status", pll_active, 0);
      wait_cyc(100);
      chk("R9 cancelled wait stays divider", pll_active, 0);
      chk("R9 cancelled ratio", mult_ratio, 2);
   endtask

   initial begin
      repeat (200000) @(posedge clk_in);
      errors++;
      $display("FAIL watchdog: actual expired expected done");
      summary();
   end

   initial begin
      t_reset();
      t_readback_run();
      t_div_decode();
      t_pll_int();
      t_pll_frac();
      t_lock_count();
      t_no_reload();
      t_reserved();
      t_div_back();
      summary();
   end

endmodule